// File: doc/BRIEF.md
# Per-Line Sensed External Interrupt Controller

This block watches up to 32 external interrupt pins, each sampled on the block clock through a two-flop synchronizer. Every line has its own sense setting. The setting selects low level, high level, falling edge, rising edge or both edges. A line with any other setting is inert. A qualifying event sets that line's bit in a detect register. Software clears a detect bit by writing 1 to it. An enable mask has two access points: one sets mask bits on write-1 and one clears them on write-1.

Each line drives a dedicated request output. That output is high while the line's detect bit and enable bit are both set, so a downstream controller sees each source on its own wire. Software reaches all state through a plain synchronous bus. A write takes effect at the clock edge where it is presented. A read returns its data through an output register loaded at the same edge.

In a level mode, detection re-arms on every cycle the pin holds its active level. A clear therefore only sticks once the pin has left that level. If a clear and a new event reach a bit at the same edge, the event wins.

Top module: `extint_ctrl`

## Requirements
- R1: After reset the enable mask, all detect bits and all sense settings are zero, every request output is low and the read data output is zero.
- R2: A write to offset 0x008 sets every enable bit whose data bit is 1 and leaves the others unchanged. Reads of offset 0x004 or 0x008 return the enable mask, with bit n belonging to line n.
- R3: A write to offset 0x004 clears every enable bit whose data bit is 1 and leaves the others unchanged.
- R4: A read of offset 0x000 returns, for each line n in bit n, its detect bit ANDed with its enable bit.
- R5: Offset 0x100 reads the detect bits. A write there clears each detect bit whose data bit is 1 and leaves the bits written with 0 unchanged.
- R6: Line n has a sense register at offset 0x180 + 4*n. Its bits [5:0] are written from data bits [5:0] and read back with all upper bits zero. The codes are 0x01 for low level, 0x02 for high level, 0x04 for falling edge, 0x08 for rising edge and 0x0C for both edges.
- R7: Edge modes compare successive synchronized samples. With two synchronizer stages, a pin change presented before clock edge k sets the detect bit at edge k+2. The request output is high after edge k+2 and not before.
- R8: In a level mode, the detect bit is set on every cycle the synchronized pin is at its active level. A write-1 clear during that time leaves the bit set, and the same clear after the level is gone takes effect.
- R9: A sense code other than the five listed in R6, including the reset value 0x00, never sets that line's detect bit.
- R10: When a new event and a write-1 clear reach the same detect bit at the same edge, the bit remains set.
- R11: Request output n equals detect bit n ANDed with enable bit n, independently for every line.
- R12: Read data is loaded at the edge where a read is presented and held until the next read. Reads of unmapped offsets return zero. Writes to offset 0x000 or to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Bus access strobe for this cycle |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W (12) | Byte offset of the access |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Registered read data |
| irq_pin_i | input | N_LINES (32) | Asynchronous external interrupt pins |
| irq_req_o | output | N_LINES (32) | Per-line interrupt requests |

## Verification
A pin change presented before an edge reaches the request output three edges later: two synchronizer stages, then the detect register. Enable and detect writes show on the request output right after the edge that takes them. Read data is due at the edge that takes the read. The bench keeps a cycle-accurate reference, updated at each rising edge from the inputs presented before that edge. It compares every output at the following falling edge, so each result is judged in exactly the cycle it is due. Directed sequences time the three-edge edge path, the level re-arm against a clear, and a clear meeting an event at the same edge.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef logic [5:0] sense_t;

  // sense codes for one line
  localparam sense_t SNS_LOW  = 6'h01;
  localparam sense_t SNS_HIGH = 6'h02;
  localparam sense_t SNS_FALL = 6'h04;
  localparam sense_t SNS_RISE = 6'h08;
  localparam sense_t SNS_BOTH = 6'h0C;

  // byte offsets of the register file
  localparam int unsigned OFS_REQ   = 32'h000;
  localparam int unsigned OFS_ENCLR = 32'h004;
  localparam int unsigned OFS_ENSET = 32'h008;
  localparam int unsigned OFS_DET   = 32'h100;
  localparam int unsigned OFS_CFG   = 32'h180;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/extint_line.sv
module extint_line
  import extint_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   samp_i,
  input  logic   cfg_we_i,
  input  sense_t cfg_wdata_i,
  input  logic   det_clr_i,
  output sense_t cfg_o,
  output logic   det_o
);

  logic   prev_q;
  sense_t cfg_q;
  logic   det_q;
  logic   det_d;
  logic   det_upd;
  logic   hit;
  logic   rise;
  logic   fall;
  logic   valid_code;

  assign rise = samp_i & ~prev_q;
  assign fall = ~samp_i & prev_q;

  always_comb begin
    case (cfg_q)
      SNS_LOW:  hit = ~samp_i;
      SNS_HIGH: hit = samp_i;
      SNS_FALL: hit = fall;
      SNS_RISE: hit = rise;
      SNS_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
  end

  assign valid_code = (cfg_q == SNS_LOW) || (cfg_q == SNS_HIGH) ||
                      (cfg_q == SNS_FALL) || (cfg_q == SNS_RISE) ||
                      (cfg_q == SNS_BOTH);

  // an event outranks a clear arriving at the same edge
  assign det_d   = (det_q & ~det_clr_i) | hit;
  assign det_upd = hit | det_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= samp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      det_q <= 1'b0;
    else if (det_upd) det_q <= det_d;
  end

  assign cfg_o = cfg_q;
  assign det_o = det_q;

  // R5: a detect bit only drops after a write-1 clear
  a_r5_fall_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(det_q) |-> $past(det_clr_i));

  // R9: an unlisted code never raises detection
  a_r9_invalid_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_code && !det_q) |=> !det_q);

  // R8: active level keeps the bit set, whatever the clear does
  a_r8_level_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((cfg_q == SNS_HIGH) && samp_i) || ((cfg_q == SNS_LOW) && !samp_i)) |=> det_q);

  // R7: a rising sample pair in rising mode sets the bit next edge
  a_r7_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg_q == SNS_RISE) && samp_i && !prev_q) |=> det_q);

  // R10: event beats a simultaneous clear
  a_r10_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_clr_i && (cfg_q == SNS_BOTH) && (samp_i != prev_q)) |=> det_q);

endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_sel_i,
  input  logic               bus_wr_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  input  logic [N-1:0]       det_i,
  input  sense_t [N-1:0]     cfg_i,
  output logic [N-1:0]       en_o,
  output logic [N-1:0]       det_clr_o,
  output logic [N-1:0]       cfg_we_o,
  output sense_t             cfg_wdata_o
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [AW-1:0] A_REQ     = AW'(OFS_REQ);
  localparam logic [AW-1:0] A_ENCLR   = AW'(OFS_ENCLR);
  localparam logic [AW-1:0] A_ENSET   = AW'(OFS_ENSET);
  localparam logic [AW-1:0] A_DET     = AW'(OFS_DET);
  localparam logic [AW-1:0] A_CFG     = AW'(OFS_CFG);
  localparam logic [AW-1:0] A_CFG_END = AW'(OFS_CFG + 4 * N);

  logic          wr_stb, rd_stb;
  logic          hit_req, hit_clr, hit_set, hit_det, hit_cfg;
  logic [AW-1:0] cfg_rel;
  logic [IW-1:0] cfg_idx;
  logic [N-1:0]  set_mask, clr_mask;
  logic [N-1:0]  en_q, en_d;
  logic          en_upd;
  logic [DW-1:0] rdata_q, rd_d;
  logic          unused_wdata;
  logic          unused_rel;

  assign wr_stb = bus_sel_i & bus_wr_i;
  assign rd_stb = bus_sel_i & ~bus_wr_i;

  assign hit_req = (bus_addr_i == A_REQ);
  assign hit_clr = (bus_addr_i == A_ENCLR);
  assign hit_set = (bus_addr_i == A_ENSET);
  assign hit_det = (bus_addr_i == A_DET);
  assign hit_cfg = (bus_addr_i >= A_CFG) && (bus_addr_i < A_CFG_END) &&
                   (bus_addr_i[1:0] == 2'b00);

  assign cfg_rel = bus_addr_i - A_CFG;
  assign cfg_idx = cfg_rel[IW+1:2];

  assign unused_wdata = ^bus_wdata_i;
  assign unused_rel   = ^cfg_rel;

  assign set_mask  = (wr_stb && hit_set) ? bus_wdata_i[N-1:0] : '0;
  assign clr_mask  = (wr_stb && hit_clr) ? bus_wdata_i[N-1:0] : '0;
  assign det_clr_o = (wr_stb && hit_det) ? bus_wdata_i[N-1:0] : '0;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cfg_we_o[i] = wr_stb && hit_cfg && (cfg_idx == IW'(i));
    end
  end
  assign cfg_wdata_o = bus_wdata_i[5:0];

  // enable mask next state
  assign en_d   = (en_q | set_mask) & ~clr_mask;
  assign en_upd = wr_stb & (hit_set | hit_clr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= '0;
    else if (en_upd) en_q <= en_d;
  end

  // read mux
  always_comb begin
    rd_d = '0;
    if (hit_req) begin
      rd_d = DW'(det_i & en_q);
    end else if (hit_clr || hit_set) begin
      rd_d = DW'(en_q);
    end else if (hit_det) begin
      rd_d = DW'(det_i);
    end else if (hit_cfg) begin
      for (int i = 0; i < N; i++) begin
        if (cfg_idx == IW'(i)) rd_d = DW'(cfg_i[i]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_stb) rdata_q <= rd_d;
  end

  assign en_o        = en_q;
  assign bus_rdata_o = rdata_q;

  // R2: an enable bit rises only through the set offset
  a_r2_en_rise_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(en_q & ~$past(en_q))) |-> $past(wr_stb && hit_set));

  // R3: an enable bit falls only through the clear offset
  a_r3_en_fall_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~en_q & $past(en_q))) |-> $past(wr_stb && hit_clr));

  // R12: read data holds without a read
  a_r12_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_stb) |-> $stable(rdata_q));

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int N_LINES     = 32,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_sel_i,
  input  logic                bus_wr_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic [N_LINES-1:0]  irq_pin_i,
  output logic [N_LINES-1:0]  irq_req_o
);

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic [N_LINES-1:0]   samp;
  logic [N_LINES-1:0]   det_all;
  logic [N_LINES-1:0]   en_all;
  logic [N_LINES-1:0]   det_clr;
  logic [N_LINES-1:0]   cfg_we;
  sense_t               cfg_wdata;
  sense_t [N_LINES-1:0] cfg_all;

  // reset: asserted at once, released on the second clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  extint_sync #(
    .W      (N_LINES),
    .STAGES (SYNC_STAGES)
  ) i_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .d_i    (irq_pin_i),
    .q_o    (samp)
  );

  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    extint_line i_line (
      .clk_i       (clk_i),
      .rst_ni      (rst_int_n),
      .samp_i      (samp[n]),
      .cfg_we_i    (cfg_we[n]),
      .cfg_wdata_i (cfg_wdata),
      .det_clr_i   (det_clr[n]),
      .cfg_o       (cfg_all[n]),
      .det_o       (det_all[n])
    );
  end

  extint_regs #(
    .N  (N_LINES),
    .AW (ADDR_W),
    .DW (DATA_W)
  ) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .det_i       (det_all),
    .cfg_i       (cfg_all),
    .en_o        (en_all),
    .det_clr_o   (det_clr),
    .cfg_we_o    (cfg_we),
    .cfg_wdata_o (cfg_wdata)
  );

  assign irq_req_o = det_all & en_all;

endmodule

// File: tb/test_extint_ctrl.sv
module test_extint_ctrl;

  localparam int N  = 32;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel, wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [N-1:0]  pins;
  logic [N-1:0]  irq;

  always #5 clk = ~clk;

  extint_ctrl #(.N_LINES(N), .ADDR_W(AW), .DATA_W(DW)) i_extint_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_pin_i(pins), .irq_req_o(irq)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string cur_req = "R11";

  // reference state
  logic [N-1:0]  m_ff1, m_ff2, m_prev, m_det, m_en;
  logic [5:0]    m_cfg [N];
  logic [DW-1:0] m_rd;
  logic [AW-1:0] m_rd_addr;

  function automatic logic sense_hit(logic [5:0] c, logic s, logic p);
    case (c)
      6'h01:   return !s;
      6'h02:   return s;
      6'h04:   return !s && p;
      6'h08:   return s && !p;
      6'h0C:   return s != p;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit is_cfg(logic [AW-1:0] a);
    return (a >= 12'h180) && (a < 12'h200) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
    if (a == 12'h000) return m_det & m_en;
    if (a == 12'h004 || a == 12'h008) return m_en;
    if (a == 12'h100) return m_det;
    if (is_cfg(a)) return {26'b0, m_cfg[(a - 12'h180) >> 2]};
    return '0;
  endfunction

  function automatic string tag_of(logic [AW-1:0] a);
    if (a == 12'h000) return "R4";
    if (a == 12'h004 || a == 12'h008) return "R2";
    if (a == 12'h100) return "R5";
    if (is_cfg(a)) return "R6";
    return "R12";
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference update at each rising edge from the inputs presented before it
  always @(posedge clk) begin : ref_model
    logic [N-1:0] evv;
    logic [N-1:0] clr;
    if (!rst_n) begin
      m_ff1 = '0; m_ff2 = '0; m_prev = '0; m_det = '0; m_en = '0;
      m_rd = '0; m_rd_addr = 12'hFFF;
      for (int i = 0; i < N; i++) m_cfg[i] = 6'h00;
    end else begin
      for (int i = 0; i < N; i++) evv[i] = sense_hit(m_cfg[i], m_ff2[i], m_prev[i]);
      if (sel && !wr) begin
        m_rd      = exp_read(addr);
        m_rd_addr = addr;
      end
      clr   = (sel && wr && addr == 12'h100) ? wdata : '0;
      m_det = (m_det & ~clr) | evv;
      if (sel && wr && addr == 12'h008) m_en = m_en | wdata;
      if (sel && wr && addr == 12'h004) m_en = m_en & ~wdata;
      if (sel && wr && is_cfg(addr)) m_cfg[(addr - 12'h180) >> 2] = wdata[5:0];
      m_prev = m_ff2;
      m_ff2  = m_ff1;
      m_ff1  = pins;
    end
  end

  // compare outputs at every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, DW'(irq), DW'(m_det & m_en));
      chk(tag_of(m_rd_addr), rdata, m_rd);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(logic [AW-1:0] a);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0; pins = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1: reset state
    cur_req = "R1";
    chk("R1", DW'(irq), '0);
    chk("R1", rdata, '0);
    bus_read(12'h000); chk("R1", rdata, '0);
    bus_read(12'h004); chk("R1", rdata, '0);
    bus_read(12'h100); chk("R1", rdata, '0);
    bus_read(12'h184); chk("R1", rdata, '0);

    // R6: sense register write and readback, upper bits dropped
    cur_req = "R6";
    bus_write(12'h18C, 32'hFFFF_FFC8);
    bus_read(12'h18C); chk("R6", rdata, 32'h0000_0008);

    // R2: set enables; zeros do nothing; both offsets read the mask
    cur_req = "R2";
    bus_write(12'h008, 32'h0000_00F0);
    bus_write(12'h008, 32'h0000_0000);
    bus_read(12'h004); chk("R2", rdata, 32'h0000_00F0);
    bus_read(12'h008); chk("R2", rdata, 32'h0000_00F0);

    // R3: clear enables
    cur_req = "R3";
    bus_write(12'h004, 32'h0000_0030);
    bus_read(12'h004); chk("R3", rdata, 32'h0000_00C0);

    // R7: rising edge on line 0, due exactly three edges after the pin change
    cur_req = "R7";
    bus_write(12'h180, 32'h08);
    bus_write(12'h184, 32'h04);
    bus_write(12'h188, 32'h0C);
    bus_write(12'h008, 32'h0000_003F);
    tick(2);
    pins[0] = 1'b1;
    tick(1); chk("R7", DW'(irq[0]), 0);
    tick(1); chk("R7", DW'(irq[0]), 0);
    tick(1); chk("R7", DW'(irq[0]), 1);
    pins[1] = 1'b1; tick(4);
    pins[1] = 1'b0; tick(4);
    chk("R7", DW'(irq[1]), 1);
    bus_write(12'h100, 32'h0000_0003);
    chk("R7", DW'(irq[1:0]), 0);

    // R8: high level re-arms against a clear until the pin drops
    cur_req = "R8";
    bus_write(12'h190, 32'h02);
    bus_write(12'h008, 32'h0000_0010);
    pins[4] = 1'b1; tick(4);
    chk("R8", DW'(irq[4]), 1);
    bus_write(12'h100, 32'h0000_0010);
    chk("R8", DW'(irq[4]), 1);
    pins[4] = 1'b0; tick(3);
    bus_write(12'h100, 32'h0000_0010);
    chk("R8", DW'(irq[4]), 0);

    // R9: unlisted code keeps line 5 inert
    cur_req = "R9";
    bus_write(12'h194, 32'h03);
    bus_write(12'h008, 32'h0000_0020);
    for (int k = 0; k < 4; k++) begin
      pins[5] = ~pins[5]; tick(3);
    end
    chk("R9", DW'(irq[5]), 0);
    bus_read(12'h100); chk("R9", DW'(rdata[5]), 0);

    // R10: event and clear at the same edge on a both-edges line
    cur_req = "R10";
    pins[2] = 1'b1; tick(4);
    chk("R10", DW'(irq[2]), 1);
    pins[2] = 1'b0; tick(2);
    bus_write(12'h100, 32'h0000_0004);
    chk("R10", DW'(irq[2]), 1);
    bus_write(12'h100, 32'h0000_0004);
    chk("R10", DW'(irq[2]), 0);

    // R12: unmapped read, ignored writes, held read data
    cur_req = "R12";
    bus_read(12'h010); chk("R12", rdata, '0);
    bus_write(12'h000, 32'hFFFF_FFFF);
    bus_write(12'h040, 32'hFFFF_FFFF);
    bus_write(12'h204, 32'h0000_003F);
    bus_read(12'h008); chk("R12", rdata, DW'(m_en));
    tick(3); chk("R12", rdata, DW'(m_en));

    // R11 with R4/R5/R6/R2 reads: random stimulus
    cur_req = "R11";
    for (int i = 0; i < N; i++) begin
      logic [5:0] code;
      case ($urandom_range(0, 5))
        0: code = 6'h01; 1: code = 6'h02; 2: code = 6'h04;
        3: code = 6'h08; 4: code = 6'h0C; default: code = 6'h10;
      endcase
      bus_write(AW'(12'h180 + 4 * i), DW'(code));
    end
    bus_write(12'h008, $urandom);
    for (int c = 0; c < 4000; c++) begin
      pins = pins ^ ($urandom & $urandom & $urandom);
      if ($urandom_range(0, 3) == 0) begin
        sel = 1'b1;
        wr  = 1'($urandom_range(0, 1));
        case ($urandom_range(0, 6))
          0: addr = 12'h000;
          1: addr = 12'h004;
          2: addr = 12'h008;
          3: addr = 12'h100;
          4: addr = AW'(12'h180 + 4 * $urandom_range(0, N - 1));
          5: addr = 12'h0F0;
          default: addr = 12'h100;
        endcase
        wdata = $urandom;
      end else begin
        sel = 1'b0;
        wr  = 1'b0;
      end
      @(negedge clk);
    end
    sel = 1'b0; wr = 1'b0;
    tick(2);
    finish_run();
  end

endmodule